// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds the eight 16-bit working registers of a small processor datapath. Each register is picked by a 3-bit code. The four data registers can also be handled as two separate 8-bit halves. Two read ports and one write port each carry a word/byte mode flag beside their 3-bit select, and each port reads the select one way in word mode and another way in byte mode. A byte write replaces only the addressed half of its register and keeps the other half.

The stack pointer has two more operations, one for a push and one for a pop. Each moves the pointer by one word step. This lets a stack operation update the pointer without using the write port.

Reads are combinational views of the stored state. A write or a stack step takes effect at the next rising clock edge. Reset is synchronous.

Top module: `gpr_file`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to 0x0000. The clear shows on every read from the following cycle.
- R2: In word mode the select codes name the registers as follows: 000 first data register, 001 second, 010 third, 011 fourth, 100 stack pointer, 101 frame pointer, 110 source index, 111 destination index. A word read returns all 16 bits.
- R3: In byte mode, select bit 2 picks the half (0 = bits 7:0, 1 = bits 15:8) and bits 1:0 pick one of the data registers 000 to 011 in the word numbering. For example, byte code 101 is bits 15:8 of the register with word code 001.
- R4: A byte write copies `wr_data[7:0]` into the selected half only. The other half of that register keeps its value.
- R5: A byte read returns the selected byte in bits 7:0 of the read bus, and bits 15:8 are zero.
- R6: A write is seen by the reads in the cycle after its clock edge. A read of the same register in the same cycle as the write returns the old value.
- R7: A write changes only the register it addresses. With `wr_en` low, no register changes except through a stack step.
- R8: `sp_push` alone lowers the stack pointer (word code 100) by 2, and `sp_pop` alone raises it by 2, both modulo 2^16.
- R9: `sp_push` and `sp_pop` together leave the stack pointer unchanged.
- R10: A word write to the stack pointer in the same cycle as a stack step takes precedence. The pointer then takes the written value.
- R11: The two read ports work independently. They may use different modes and the same or different registers in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 3 | Read port A register code |
| rd_a_byte | input | 1 | Read port A byte mode when high |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 3 | Read port B register code |
| rd_b_byte | input | 1 | Read port B byte mode when high |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Write register code |
| wr_byte | input | 1 | Write byte mode when high |
| wr_data | input | 16 | Write data (bits 7:0 only in byte mode) |
| sp_push | input | 1 | Step stack pointer down by one word |
| sp_pop | input | 1 | Step stack pointer up by one word |

## Verification
Read data is combinational, so a read result is due in the same cycle its select is applied. A write, a stack step or a reset is due on the reads one rising edge later. The bench drives every input just after a falling edge and checks both read buses one nanosecond later. This is still before the next rising edge, so every check compares against the bench's model of the state as it stood before that edge. The model is updated at the rising edge from the inputs applied in that cycle, so results due one edge later are checked in the following cycle, and a same-cycle read after a write confirms that the old value is returned.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   // Which part of a register a port touches.
   typedef enum logic [1:0] {
      LANE_WORD = 2'd0,
      LANE_LO   = 2'd1,
      LANE_HI   = 2'd2
   } lane_e;

   // True when the lane includes the low half.
   function automatic logic lane_has_lo(lane_e l);
      return (l == LANE_WORD) || (l == LANE_LO);
   endfunction

   // True when the lane includes the high half.
   function automatic logic lane_has_hi(lane_e l);
      return (l == LANE_WORD) || (l == LANE_HI);
   endfunction

endpackage

// File: rtl/gpr_sel_decode.sv
// Turns a port's code and mode flag into a register index and a lane.
module gpr_sel_decode
   import gpr_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             byte_mode,
   output logic [SEL_W-1:0] idx,
   output lane_e            lane
);

   generate
      if (SEL_W < 2) begin : g_bad_sel
         $error("gpr_sel_decode: SEL_W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (byte_mode) begin
         // Top bit picks the half; the rest names a data register in the lower half of the map.
         idx  = {1'b0, sel[SEL_W-2:0]};
         lane = sel[SEL_W-1] ? LANE_HI : LANE_LO;
      end else begin
         idx  = sel;
         lane = LANE_WORD;
      end
   end

endmodule

// File: rtl/gpr_read_port.sv
// One read port: picks a register and applies the lane, zero-extending bytes.
module gpr_read_port
   import gpr_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int SEL_W  = 3,
   localparam int NREG  = 1 << SEL_W,
   localparam int HALF  = WORD_W / 2
) (
   input  logic [WORD_W-1:0] regs [NREG],
   input  logic [SEL_W-1:0]  idx,
   input  lane_e             lane,
   output logic [WORD_W-1:0] data
);

   logic [WORD_W-1:0] word;

   assign word = regs[idx];

   always_comb begin
      unique case (lane)
         LANE_LO: data = {{(WORD_W-HALF){1'b0}}, word[HALF-1:0]};
         LANE_HI: data = {{(WORD_W-HALF){1'b0}}, word[WORD_W-1:HALF]};
         default: data = word;
      endcase
   end

endmodule

// File: rtl/gpr_reg_cell.sv
// One register with separate lane write enables and optional step up/down.
module gpr_reg_cell #(
   parameter int WORD_W  = 16,
   parameter int STEP    = 2,
   localparam int HALF   = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              step_dn,
   input  logic              step_up,
   output logic [WORD_W-1:0] q
);

   localparam logic [WORD_W-1:0] STEP_V = WORD_W'(STEP);

   logic any_wr;
   logic do_dn;
   logic do_up;

   assign any_wr = wr_lo | wr_hi;
   assign do_dn  = !any_wr && step_dn && !step_up;
   assign do_up  = !any_wr && step_up && !step_dn;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (any_wr) begin
         if (wr_lo) q[HALF-1:0]      <= wr_data[HALF-1:0];
         if (wr_hi) q[WORD_W-1:HALF] <= wr_data[WORD_W-1:HALF];
      end else if (do_dn) begin
         q <= q - STEP_V;
      end else if (do_up) begin
         q <= q + STEP_V;
      end
   end

   // R1: synchronous clear
   a_r1_reset_clear: assert property (@(posedge clk) rst |=> q == '0);

   // R4: low-lane write keeps the high half
   a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
      (wr_lo && !wr_hi) |=> q[WORD_W-1:HALF] == $past(q[WORD_W-1:HALF]));

   // R4: high-lane write keeps the low half
   a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && !wr_lo) |=> q[HALF-1:0] == $past(q[HALF-1:0]));

   // R7 and R9: no write and no net step leaves the value alone
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!wr_lo && !wr_hi && (step_dn == step_up)) |=> $stable(q));

   // R8: a lone down step subtracts the step size
   a_r8_push_down: assert property (@(posedge clk) disable iff (rst)
      (!wr_lo && !wr_hi && step_dn && !step_up) |=> q == $past(q) - STEP_V);

   // R8: a lone up step adds the step size
   a_r8_pop_up: assert property (@(posedge clk) disable iff (rst)
      (!wr_lo && !wr_hi && step_up && !step_dn) |=> q == $past(q) + STEP_V);

endmodule

// File: rtl/gpr_file.sv
module gpr_file
   import gpr_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int SEL_W   = 3,
   parameter int SP_CODE = 4,
   parameter int SP_STEP = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  rd_a_sel,
   input  logic              rd_a_byte,
   output logic [WORD_W-1:0] rd_a_data,
   input  logic [SEL_W-1:0]  rd_b_sel,
   input  logic              rd_b_byte,
   output logic [WORD_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_byte,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              sp_push,
   input  logic              sp_pop
);

   localparam int NREG     = 1 << SEL_W;
   localparam int HALF     = WORD_W / 2;
   localparam int RD_PORTS = 2;

   // Elaboration-time parameter checks
   generate
      if ((WORD_W < 2) || ((WORD_W % 2) != 0)) begin : g_bad_width
         $error("gpr_file: WORD_W must be even and at least 2");
      end
      if ((SP_CODE < 0) || (SP_CODE >= NREG)) begin : g_bad_sp
         $error("gpr_file: SP_CODE outside the register map");
      end
      if ((SP_STEP < 1) || (SP_STEP >= (1 << (WORD_W - 1)))) begin : g_bad_step
         $error("gpr_file: SP_STEP out of range");
      end
   endgenerate

   logic [WORD_W-1:0] regs [NREG];

   // Write side
   logic [SEL_W-1:0]  w_idx;
   lane_e             w_lane;
   logic [WORD_W-1:0] w_aligned;

   gpr_sel_decode #(.SEL_W(SEL_W)) u_wr_dec (
      .sel       (wr_sel),
      .byte_mode (wr_byte),
      .idx       (w_idx),
      .lane      (w_lane)
   );

   // Byte data is copied into both lanes; the lane enables choose which lands.
   assign w_aligned = wr_byte ? {wr_data[HALF-1:0], wr_data[HALF-1:0]} : wr_data;

   genvar r;
   generate
      for (r = 0; r < NREG; r++) begin : g_reg
         logic hit;
         logic lo_en;
         logic hi_en;
         logic dn;
         logic up;

         assign hit   = wr_en && (w_idx == SEL_W'(r));
         assign lo_en = hit && lane_has_lo(w_lane);
         assign hi_en = hit && lane_has_hi(w_lane);

         if (r == SP_CODE) begin : g_sp
            assign dn = sp_push;
            assign up = sp_pop;
         end else begin : g_plain
            assign dn = 1'b0;
            assign up = 1'b0;
         end

         gpr_reg_cell #(.WORD_W(WORD_W), .STEP(SP_STEP)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .wr_lo   (lo_en),
            .wr_hi   (hi_en),
            .wr_data (w_aligned),
            .step_dn (dn),
            .step_up (up),
            .q       (regs[r])
         );
      end
   endgenerate

   // Read side
   logic [SEL_W-1:0]  rp_sel  [RD_PORTS];
   logic              rp_byte [RD_PORTS];
   logic [WORD_W-1:0] rp_data [RD_PORTS];

   assign rp_sel[0]  = rd_a_sel;
   assign rp_byte[0] = rd_a_byte;
   assign rp_sel[1]  = rd_b_sel;
   assign rp_byte[1] = rd_b_byte;
   assign rd_a_data  = rp_data[0];
   assign rd_b_data  = rp_data[1];

   genvar p;
   generate
      for (p = 0; p < RD_PORTS; p++) begin : g_rd
         logic [SEL_W-1:0] idx;
         lane_e            lane;

         gpr_sel_decode #(.SEL_W(SEL_W)) u_dec (
            .sel       (rp_sel[p]),
            .byte_mode (rp_byte[p]),
            .idx       (idx),
            .lane      (lane)
         );

         gpr_read_port #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_port (
            .regs (regs),
            .idx  (idx),
            .lane (lane),
            .data (rp_data[p])
         );
      end
   endgenerate

   // R5: byte reads carry zeros in the upper half
   a_r5_zero_ext_a: assert property (@(posedge clk) disable iff (rst)
      rd_a_byte |-> rd_a_data[WORD_W-1:HALF] == '0);
   a_r5_zero_ext_b: assert property (@(posedge clk) disable iff (rst)
      rd_b_byte |-> rd_b_data[WORD_W-1:HALF] == '0);

   // R10: a word write to the stack pointer overrides any stack step
   a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_byte && (wr_sel == SEL_W'(SP_CODE))) |=> regs[SP_CODE] == $past(wr_data));

   // R6: a word read one cycle after a word write sees the written data
   a_r6_write_seen: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_byte && !(sp_push ^ sp_pop)) ##1 (!rd_a_byte && (rd_a_sel == $past(wr_sel)))
      |-> rd_a_data == $past(wr_data));

endmodule

// File: tb/gpr_file_tb.sv
`timescale 1ns/1ps
module gpr_file_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  rd_a_sel, rd_b_sel, wr_sel;
   logic        rd_a_byte, rd_b_byte, wr_byte, wr_en;
   logic [15:0] rd_a_data, rd_b_data, wr_data;
   logic        sp_push, sp_pop;

   int checks = 0;
   int errors = 0;
   logic [15:0] m [8];

   always #2.5 clk = ~clk;

   gpr_file u_dut (
      .clk(clk), .rst(rst),
      .rd_a_sel(rd_a_sel), .rd_a_byte(rd_a_byte), .rd_a_data(rd_a_data),
      .rd_b_sel(rd_b_sel), .rd_b_byte(rd_b_byte), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
      .sp_push(sp_push), .sp_pop(sp_pop)
   );

   // Expected read value from the requirements (R2, R3, R5)
   function automatic logic [15:0] model_rd(logic [2:0] sel, logic bm);
      logic [15:0] w;
      if (!bm) return m[sel];
      w = m[{1'b0, sel[1:0]}];
      return sel[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
   endfunction

   // Next-state model (R1, R4, R7, R8, R9, R10)
   task automatic model_apply();
      logic sp_wr;
      if (rst) begin
         for (int i = 0; i < 8; i++) m[i] = 16'h0;
      end else begin
         sp_wr = wr_en && !wr_byte && (wr_sel == 3'd4);
         if (wr_en) begin
            if (!wr_byte) m[wr_sel] = wr_data;
            else if (wr_sel[2]) m[{1'b0, wr_sel[1:0]}][15:8] = wr_data[7:0];
            else m[{1'b0, wr_sel[1:0]}][7:0] = wr_data[7:0];
         end
         if (!sp_wr && (sp_push != sp_pop))
            m[4] = sp_push ? m[4] - 16'd2 : m[4] + 16'd2;
      end
   endtask

   task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_apply();
      @(negedge clk);
   endtask

   task automatic idle();
      rst = 0; wr_en = 0; wr_sel = 0; wr_byte = 0; wr_data = 0;
      sp_push = 0; sp_pop = 0;
   endtask

   task automatic rd_check(string tag, logic [2:0] sa, logic ba, logic [2:0] sb, logic bb);
      rd_a_sel = sa; rd_a_byte = ba; rd_b_sel = sb; rd_b_byte = bb;
      #1;
      chk(tag, rd_a_data, model_rd(sa, ba));
      chk(tag, rd_b_data, model_rd(sb, bb));
   endtask

   task automatic wr_word(logic [2:0] s, logic [15:0] d);
      idle(); wr_en = 1; wr_sel = s; wr_data = d; tick(); idle();
   endtask

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 8; i++) m[i] = 16'hxxxx;
      idle(); rd_a_sel = 0; rd_a_byte = 0; rd_b_sel = 0; rd_b_byte = 0;
      @(negedge clk);
      wr_en = 1; wr_data = 16'hFFFF; rst = 1; sp_push = 1;
      tick(); tick();
      idle();

      // R1: all registers cleared
      for (int i = 0; i < 8; i += 2) rd_check("R1", 3'(i), 0, 3'(i + 1), 0);

      // R2: word codes address distinct registers
      for (int i = 0; i < 8; i++) wr_word(3'(i), 16'h1111 * 16'(i + 1) ^ 16'h0F0F);
      for (int i = 0; i < 8; i += 2) rd_check("R2", 3'(i), 0, 3'(i + 1), 0);

      // R3 and R5: byte codes map to halves, zero-extended
      wr_word(3'd0, 16'h1234); wr_word(3'd1, 16'h5678);
      wr_word(3'd2, 16'h9ABC); wr_word(3'd3, 16'hDEF0);
      rd_check("R3", 3'd0, 1, 3'd4, 1);
      chk("R5", rd_a_data, 16'h0034);
      chk("R3", rd_b_data, 16'h0012);
      rd_check("R3", 3'd5, 1, 3'd3, 1);
      chk("R3", rd_a_data, 16'h0056);
      chk("R5", rd_b_data, 16'h00F0);
      rd_check("R3", 3'd6, 1, 3'd7, 1);

      // R4: byte write to a high half keeps the low half
      idle(); wr_en = 1; wr_byte = 1; wr_sel = 3'd4; wr_data = 16'h77AB; tick(); idle();
      rd_check("R4", 3'd0, 0, 3'd0, 1);
      chk("R4", rd_a_data, 16'hAB34);
      idle(); wr_en = 1; wr_byte = 1; wr_sel = 3'd3; wr_data = 16'h55CD; tick(); idle();
      rd_check("R4", 3'd3, 0, 3'd7, 1);
      chk("R4", rd_a_data, 16'hDECD);

      // R6: same-cycle read returns the old value
      idle(); wr_en = 1; wr_sel = 3'd6; wr_data = 16'hBEEF;
      rd_check("R6", 3'd6, 0, 3'd6, 0);
      tick(); idle();
      rd_check("R6", 3'd6, 0, 3'd5, 0);
      chk("R6", rd_a_data, 16'hBEEF);

      // R7: no write enable, nothing moves
      idle(); wr_sel = 3'd2; wr_data = 16'hAAAA; tick();
      for (int i = 0; i < 8; i += 2) rd_check("R7", 3'(i), 0, 3'(i + 1), 0);

      // R8: push from zero wraps, pop restores
      wr_word(3'd4, 16'h0000);
      idle(); sp_push = 1; tick(); idle();
      rd_check("R8", 3'd4, 0, 3'd0, 0);
      chk("R8", rd_a_data, 16'hFFFE);
      idle(); sp_pop = 1; tick(); idle();
      rd_check("R8", 3'd4, 0, 3'd5, 0);
      chk("R8", rd_a_data, 16'h0000);

      // R9: push with pop is no step
      idle(); sp_push = 1; sp_pop = 1; tick(); idle();
      rd_check("R9", 3'd4, 0, 3'd4, 0);

      // R10: write to the stack pointer beats a step
      idle(); wr_en = 1; wr_sel = 3'd4; wr_data = 16'h0100; sp_push = 1; tick(); idle();
      rd_check("R10", 3'd4, 0, 3'd1, 0);
      chk("R10", rd_a_data, 16'h0100);

      // R11: random traffic on both ports
      for (int n = 0; n < 4000; n++) begin
         idle();
         rst      = ($urandom_range(0, 199) == 0);
         wr_en    = $urandom_range(0, 1);
         wr_sel   = 3'($urandom);
         wr_byte  = $urandom_range(0, 1);
         wr_data  = 16'($urandom);
         sp_push  = ($urandom_range(0, 3) == 0);
         sp_pop   = ($urandom_range(0, 3) == 0);
         rd_check("R11", 3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom));
         tick();
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule